// File: doc/BRIEF.md
# Whole-Window Acknowledging Bus Slave

This block is the slave-side decoder behind a simple peripheral-bus interface. The interface gives it one chip select for a contiguous 8 KB window, along with a read-not-write flag, a word address, write data and byte enables. The block does its own decoding inside that window instead of relying on one chip enable per register. It raises exactly one acknowledge for every access that hits the window, so an offset with nothing behind it can never leave the bus master waiting forever.

The top word-address bit splits the window into two halves. One half is a memory region of two RAM banks, and the next address bit picks the bank. The other half is a register region: a ten-bit word offset picks a register, and only the lowest 19 offsets hold storage. Accesses to the other register offsets are still acknowledged. Writes there are dropped and reads there return zero.

Top module: `ws_bus_slave`

## Requirements
- R1: Every access with `cs` high gets an acknowledge, whatever its address in the window. No acknowledge is raised while `cs` is low.
- R2: With `rnw` = 1 the access is answered on `rd_ack`. With `rnw` = 0 it is answered on `wr_ack`. The two are never high together.
- R3: Word-address bit 10 selects the region: 1 selects registers, 0 selects memory. In the memory region, bit 9 selects bank 0 or bank 1, and bits 8:0 give the word inside the bank. Every memory word is separate storage.
- R4: In the register region, `addr[9:0]` is the register offset. Offsets 0 to 18 are implemented registers. A read of offset 19 to 1023 returns all zeros on `rdata` in its acknowledge cycle.
- R5: A write to an unimplemented register offset is acknowledged and changes no stored value.
- R6: Register reads and all writes are acknowledged in the first cycle `cs` is high. Memory reads are acknowledged one cycle later, with the RAM word on `rdata`.
- R7: If `cs` stays high after the acknowledge, no second acknowledge is raised. The next access starts only after `cs` has been low for at least one cycle.
- R8: On a write, `be[i]` enables the update of byte lane `wdata[8i+7:8i]`. This applies in both RAM and registers. Lanes with their enable low keep their old value.
- R9: A synchronous active-high `rst` clears every register to zero and leaves no acknowledge pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Window chip select, held until acknowledge |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | Word address within the window |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables, bit i covers byte lane i |
| rdata | output | 32 | Read data, valid with `rd_ack` |
| rd_ack | output | 1 | Read acknowledge |
| wr_ack | output | 1 | Write acknowledge |

## Verification
The bench sweeps all 2048 word addresses with writes and then reads. It does this once with full byte enables and once with mixed byte enables. The first offset past the register file, offset 19, is the corner case that would hang a per-register decoder: such a design would show a timeout at the watchdog rather than an acknowledge. A decoder that kept storage behind that offset would return nonzero data there. Holding `cs` past the acknowledge exposes a design that acknowledges twice. Measuring the acknowledge latency per region catches a memory read answered before its RAM data is valid.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic {
        REGION_MEM = 1'b0,
        REGION_REG = 1'b1
    } region_e;

    typedef struct packed {
        logic busy;   // acknowledge already given for the current cs
        logic pend;   // memory read acknowledge due this cycle
        logic bank;   // bank whose read data is pending
    } ack_state_t;

endpackage

// File: rtl/wsd_decode.sv
module wsd_decode
    import wsd_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int REG_SEL_W = 10,
    parameter int NUM_REGS  = 19
) (
    input  logic [ADDR_W-1:0]           addr,
    output region_e                     region,
    output logic                        bank_sel,
    output logic [ADDR_W-3:0]           bank_addr,
    output logic                        reg_hit,
    output logic [$clog2(NUM_REGS)-1:0] reg_idx
);
    localparam int REG_IDX_W = $clog2(NUM_REGS);

    logic [REG_SEL_W-1:0] reg_field;

    always_comb begin
        region    = region_e'(addr[ADDR_W-1]);
        bank_sel  = addr[ADDR_W-2];
        bank_addr = addr[ADDR_W-3:0];
        reg_field = addr[REG_SEL_W-1:0];
        reg_hit   = (region == REGION_REG) && (reg_field < REG_SEL_W'(NUM_REGS));
        reg_idx   = reg_field[REG_IDX_W-1:0];
    end

endmodule

// File: rtl/wsd_ack_ctrl.sv
module wsd_ack_ctrl
    import wsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic rnw,
    input  logic region_reg,
    input  logic bank_sel,
    output logic start,
    output logic rd_ack,
    output logic wr_ack,
    output logic pend_now,
    output logic pend_bank
);
    ack_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        start = cs & ~st_q.busy;
        if (!cs) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.pend = rnw & ~region_reg;
            st_d.bank = bank_sel;
        end else begin
            st_d.pend = 1'b0;
        end
        pend_now  = st_q.pend & cs;
        pend_bank = st_q.bank;
        rd_ack    = (start & rnw & region_reg) | pend_now;
        wr_ack    = start & ~rnw;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_ack_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rd_ack && wr_ack));

    assert_no_ack_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !(rd_ack || wr_ack));

    assert_single_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_ack || wr_ack) |=> !(rd_ack || wr_ack));

    assert_mem_rd_lat_R6: assert property (@(posedge clk) disable iff (rst)
        (start && rnw && !region_reg) |=> (rd_ack || !cs));

    assert_busy_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !st_q.busy);

endmodule

// File: rtl/wsd_ram_bank.sv
module wsd_ram_bank #(
    parameter int DATA_W = 32,
    parameter int AW     = 9
) (
    input  logic                clk,
    input  logic                we,
    input  logic                re,
    input  logic [AW-1:0]       addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < BE_W; i++) begin
                if (be[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
        if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/wsd_reg_file.sv
module wsd_reg_file #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 19
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [$clog2(NUM_REGS)-1:0] idx,
    input  logic                        hit,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           rdata
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) regs_d[r] = regs_q[r];
        if (we && hit) begin
            for (int i = 0; i < BE_W; i++) begin
                if (be[i]) regs_d[idx][8*i +: 8] = wdata[8*i +: 8];
            end
        end
        rdata = hit ? regs_q[idx] : '0;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rst) regs_q[r] <= '0;
            else     regs_q[r] <= regs_d[r];
        end
    end

    assert_reg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(we && hit) |=> (regs_q[0] == $past(regs_q[0]) &&
                          regs_q[NUM_REGS-1] == $past(regs_q[NUM_REGS-1])));

endmodule

// File: rtl/ws_bus_slave.sv
module ws_bus_slave
    import wsd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int REG_SEL_W = 10,
    parameter int NUM_REGS  = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                rnw,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   rdata,
    output logic                rd_ack,
    output logic                wr_ack
);
    localparam int BANK_AW   = ADDR_W - 2;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int N_BANKS   = 2;

    region_e                region;
    logic                   bank_sel;
    logic [BANK_AW-1:0]     bank_addr;
    logic                   reg_hit;
    logic [REG_IDX_W-1:0]   reg_idx;
    logic                   start, pend_now, pend_bank;
    logic                   region_reg;
    logic [DATA_W-1:0]      reg_rdata;
    logic [DATA_W-1:0]      bank_rdata [N_BANKS];

    wsd_decode #(
        .ADDR_W(ADDR_W), .REG_SEL_W(REG_SEL_W), .NUM_REGS(NUM_REGS)
    ) u_decode (
        .addr(addr), .region(region), .bank_sel(bank_sel),
        .bank_addr(bank_addr), .reg_hit(reg_hit), .reg_idx(reg_idx)
    );

    assign region_reg = (region == REGION_REG);

    wsd_ack_ctrl u_ack (
        .clk(clk), .rst(rst), .cs(cs), .rnw(rnw),
        .region_reg(region_reg), .bank_sel(bank_sel),
        .start(start), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .pend_now(pend_now), .pend_bank(pend_bank)
    );

    wsd_reg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .we(start & ~rnw), .idx(reg_idx),
        .hit(reg_hit), .wdata(wdata), .be(be), .rdata(reg_rdata)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = start & ~region_reg & (bank_sel == b[0]);
        wsd_ram_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_ram (
            .clk(clk), .we(sel & ~rnw), .re(sel & rnw), .addr(bank_addr),
            .wdata(wdata), .be(be), .rdata(bank_rdata[b])
        );
    end

    always_comb begin
        if (pend_now)        rdata = bank_rdata[pend_bank];
        else if (region_reg) rdata = reg_rdata;
        else                 rdata = '0;
    end

    assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && region_reg && !reg_hit && !pend_now) |-> (rdata == '0));

endmodule

// File: tb/tb_ws_bus_slave.sv
module tb_ws_bus_slave;
    localparam int NW = 2048;
    localparam int NREG = 19;

    logic        clk = 1'b0;
    logic        rst, cs, rnw;
    logic [10:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] rdata;
    logic        rd_ack, wr_ack;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    logic [31:0] model [NW];
    logic        got_rd, got_wr, extra;
    logic [31:0] rval;
    int          lat;

    always #10 clk = ~clk;

    ws_bus_slave dut (
        .clk(clk), .rst(rst), .cs(cs), .rnw(rnw), .addr(addr),
        .wdata(wdata), .be(be), .rdata(rdata), .rd_ack(rd_ack), .wr_ack(wr_ack)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit implemented(input logic [10:0] a);
        return !a[10] || (a[9:0] < NREG);
    endfunction

    function automatic logic [31:0] exp_read(input logic [10:0] a);
        return implemented(a) ? model[a] : 32'h0;
    endfunction

    task automatic access(input logic rd, input logic [10:0] a, input logic [31:0] wd,
                          input logic [3:0] b, input bit hold);
        @(negedge clk);
        cs = 1'b1; rnw = rd; addr = a; wdata = wd; be = b;
        lat = -1; got_rd = 1'b0; got_wr = 1'b0; rval = '0; extra = 1'b0;
        for (int n = 0; n < 4; n++) begin
            #5;
            if (rd_ack || wr_ack) begin
                lat = n; got_rd = rd_ack; got_wr = wr_ack; rval = rdata;
                break;
            end
            @(negedge clk);
        end
        if (hold) begin
            @(negedge clk); #5;
            extra = rd_ack || wr_ack;
        end
        @(negedge clk);
        cs = 1'b0;
        #5;
        check(!(rd_ack || wr_ack), "R1 idle no ack", {rd_ack, wr_ack}, 0);
    endtask

    task automatic do_write(input logic [10:0] a, input logic [31:0] d, input logic [3:0] b, input bit hold);
        access(1'b0, a, d, b, hold);
        check(lat == 0, "R6 write latency", lat, 0);
        check(got_wr && !got_rd, "R2 write ack", {got_rd, got_wr}, 1);
        if (hold) check(!extra, "R7 single ack", extra, 0);
        if (implemented(a))
            for (int i = 0; i < 4; i++) if (b[i]) model[a][8*i +: 8] = d[8*i +: 8];
    endtask

    task automatic do_read(input logic [10:0] a, input bit hold, input string tag);
        int el;
        el = a[10] ? 0 : 1;
        access(1'b1, a, 32'hDEAD_BEEF, 4'h0, hold);
        check(lat == el, "R6 read latency", lat, el);
        check(got_rd && !got_wr, "R2 read ack", {got_rd, got_wr}, 2);
        check(rval == exp_read(a), tag, rval, exp_read(a));
        if (hold) check(!extra, "R7 single ack", extra, 0);
    endtask

    function automatic logic [31:0] pat(input int a, input int salt);
        return (a * 32'h9E37_79B1) ^ (salt * 32'h0101_0101) ^ 32'h5A5A_0000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs = 1'b0; rnw = 1'b0; addr = '0; wdata = '0; be = '0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #5;
        check(!(rd_ack || wr_ack), "R9 no ack in reset", {rd_ack, wr_ack}, 0);
        @(negedge clk); rst = 1'b0;

        // R9: registers start at zero
        for (int r = 0; r < NREG; r++) do_read(11'h400 | 11'(r), 1'b0, "R9 reset value");

        // full-width write sweep over the whole window (R1, R3, R4, R5)
        for (int a = 0; a < NW; a++) do_write(11'(a), pat(a, 1), 4'hF, a % 97 == 0);
        for (int a = 0; a < NW; a++) do_read(11'(a), a % 89 == 0,
                                             a[10] ? "R4 reg read" : "R3 mem read");

        // partial byte-enable sweep (R8, R5)
        for (int a = 0; a < NW; a++) do_write(11'(a), pat(a, 7), 4'(a % 15 + 1), a % 53 == 0);
        for (int a = 0; a < NW; a++) do_read(11'(a), 1'b0, "R8 byte lanes");

        // R5: direct writes to first unimplemented offset, then check neighbours
        do_write(11'h400 | 11'd19, 32'hFFFF_FFFF, 4'hF, 1'b0);
        do_read(11'h400 | 11'd19, 1'b0, "R5 unimpl read zero");
        do_read(11'h400 | 11'd18, 1'b0, "R5 neighbour unchanged");
        do_read(11'h400 | 11'd0, 1'b0, "R5 reg0 unchanged");

        // R7: held cs on memory read and register write
        do_read(11'h0FF, 1'b1, "R7 held mem read");
        do_read(11'h2FF, 1'b1, "R7 held bank1 read");
        do_write(11'h405, 32'h1234_5678, 4'h5, 1'b1);
        do_read(11'h405, 1'b1, "R7 held reg read");

        // R9: reset clears registers again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int r = 0; r < NREG; r++) model[11'h400 | 11'(r)] = '0;
        for (int r = 0; r < NREG; r++) do_read(11'h400 | 11'(r), 1'b0, "R9 cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule